// File: doc/BRIEF.md
# Multithreaded Decode Stall and Skid Controller

This block sits in a multithreaded in-order decode stage. Packets from fetch arrive one per cycle, each tagged with a thread number. A packet carries the branch PC, a sequence number, fetch's predicted next PC, the next PC computed at decode and a mispredict flag. When the packet's thread is idle and its downstream stall is low, the packet goes straight to the stage output. When downstream stalls a thread, the controller keeps that thread's arriving packets in a private skid buffer and sends fetch one block pulse. Once the stall lifts, it replays the buffer oldest-first and then sends fetch one unblock pulse.

Each thread has its own state: idle, blocked or unblocking. A packet that leaves the stage with its mispredict flag set squashes its thread. The skid buffer is emptied, the thread returns to idle, and a redirect goes back to fetch carrying the branch's sequence number, the corrected next PC and a taken bit. The taken bit is derived from the PC values. The squashing packet itself still leaves the stage, with its next PC replaced by the computed target. Decoding and target computation happen outside this block.

The input side is valid/ready. `in_ready` is low while the skid buffer of the thread named by `in_tid` is full, and a packet offered then is dropped. The output side has no ready. Per-thread back-pressure arrives on `ds_stall`.

Top module: `dec_stall_ctl`

## Requirements
- R1: After reset, or one cycle with `init` high, every thread is idle and its skid buffer is empty. `out_valid`, `rd_valid`, `fe_block` and `fe_unblock` read 0, and `in_ready` is 1.
- R2: An accepted packet for an idle thread whose `ds_stall` bit is low appears on the `out_*` ports on the next cycle.
- R3: An accepted packet for a thread that is stalled, blocked or unblocking is written into that thread's skid buffer and is not sent to the output in that cycle.
- R4: `fe_block[t]` pulses once, one cycle after thread t goes from idle to blocked. A thread that is already blocked produces no pulse. A thread that moves from unblocking back to blocked also produces no pulse.
- R5: A blocked thread whose stall has dropped moves to unblocking. In that state its skid entries leave in arrival order. Packets that arrive during the replay are queued behind the older entries.
- R6: When a thread's skid buffer runs empty with its stall low, the thread returns to idle. `fe_unblock[t]` pulses exactly once, on the cycle the last entry appears at the output.
- R7: When a packet with the mispredict flag set leaves the stage, the redirect bundle is valid on the same cycle as that packet's output. In the bundle, `rd_valid`, `rd_mispredict` and `rd_pred_wrong` are 1, and `rd_tid`, `rd_seq` and `rd_npc` carry the packet's thread, sequence number and computed next PC. `out_npc` also carries the computed next PC. Otherwise `out_npc` is the predicted next PC.
- R8: `rd_taken` is 1 exactly when the computed next PC differs from the branch PC plus INST_BYTES (4).
- R9: A squash empties the thread's skid buffer and leaves the thread idle. A same-thread packet arriving in that cycle is discarded. If the thread was unblocking, `fe_unblock` pulses once. A squash takes precedence over any block or unblock decision in that cycle.
- R10: `fe_block[t]` and `fe_unblock[t]` are never high together.
- R11: `in_ready` is 0 while the skid buffer of thread `in_tid` holds 2×STAGE_W entries (4). A packet offered then is lost.
- R12: When a packet passes straight through, it takes the output ahead of any skid replay. Among threads that are replaying, the lowest-numbered thread goes first.
- R13: A stall on one thread does not hold back traffic on another thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Synchronous reinitialisation when taking over |
| in_valid | input | 1 | Packet offered by fetch |
| in_ready | output | 1 | Skid space available for thread `in_tid` |
| in_tid | input | TID_W (1) | Thread of the offered packet |
| in_pc | input | PC_W (32) | Branch/instruction PC |
| in_seq | input | SEQ_W (16) | Sequence number |
| in_pred_npc | input | PC_W (32) | Next PC predicted by fetch |
| in_real_npc | input | PC_W (32) | Next PC computed at decode |
| in_mispredict | input | 1 | Decode found the prediction wrong |
| ds_stall | input | NUM_THREADS (2) | Per-thread downstream stall |
| out_valid | output | 1 | Packet leaving the stage |
| out_tid | output | TID_W (1) | Its thread |
| out_pc | output | PC_W (32) | Its PC |
| out_seq | output | SEQ_W (16) | Its sequence number |
| out_npc | output | PC_W (32) | Its next PC, corrected on mispredict |
| fe_block | output | NUM_THREADS (2) | Block pulse to fetch, per thread |
| fe_unblock | output | NUM_THREADS (2) | Unblock pulse to fetch, per thread |
| rd_valid | output | 1 | Squash request to fetch |
| rd_mispredict | output | 1 | Branch mispredict flag |
| rd_pred_wrong | output | 1 | Prediction-incorrect flag |
| rd_tid | output | TID_W (1) | Squashed thread |
| rd_seq | output | SEQ_W (16) | Sequence number of the branch |
| rd_npc | output | PC_W (32) | Corrected next PC |
| rd_taken | output | 1 | Branch was taken |

## Verification
The hardest case to reach is a squash raised by a packet replayed from the skid buffer. It needs a thread blocked with a flagged packet at the head of its buffer, then released. A newer same-thread packet must also arrive in the very cycle that head is replayed. The bench stalls thread 0, feeds it a flagged packet and a clean one, and drops the stall. It offers a third packet exactly on the replay cycle. Afterwards it checks three things: a single unblock pulse, the absence of the two younger packets, and that the next packet passes straight through. A stall that returns mid-replay is driven the same way, to show that no second block pulse appears.

// File: rtl/dec_skid_pkg.sv
package dec_skid_pkg;

  typedef enum logic [1:0] {
    TS_IDLE       = 2'd0,
    TS_BLOCKED    = 2'd1,
    TS_UNBLOCKING = 2'd2
  } tstate_e;

endpackage

// File: rtl/dec_skid_fifo.sv
module dec_skid_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            push,
  input  logic                            pop,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0]      count,
  output logic                            full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= wdata;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr) |-> !full); // R11

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> (count != '0)); // R5

endmodule

// File: rtl/dec_thread_ctl.sv
module dec_thread_ctl
  import dec_skid_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              stall,
  input  logic              squash,
  input  logic              push,
  input  logic              pop,
  input  logic [CNT_W-1:0]  count,
  output tstate_e           state_q,
  output logic              blk_q,
  output logic              unblk_q
);
  tstate_e     state_d;
  logic        blk_d, unblk_d;
  logic [CNT_W:0] fill_after;
  logic        empty_after;

  assign fill_after  = {1'b0, count} + (CNT_W+1)'(push) - (CNT_W+1)'(pop);
  assign empty_after = (fill_after == '0);

  always_comb begin
    state_d = state_q;
    blk_d   = 1'b0;
    unblk_d = 1'b0;
    if (squash) begin
      state_d = TS_IDLE;
      unblk_d = (state_q != TS_IDLE);
    end else begin
      case (state_q)
        TS_IDLE: if (stall) begin
          state_d = TS_BLOCKED;
          blk_d   = 1'b1;
        end
        TS_BLOCKED: if (!stall) begin
          if (empty_after) begin
            state_d = TS_IDLE;
            unblk_d = 1'b1;
          end else begin
            state_d = TS_UNBLOCKING;
          end
        end
        TS_UNBLOCKING: begin
          if (stall) begin
            state_d = TS_BLOCKED;
          end else if (empty_after) begin
            state_d = TS_IDLE;
            unblk_d = 1'b1;
          end
        end
        default: state_d = TS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      blk_q   <= 1'b0;
      unblk_q <= 1'b0;
    end else if (init) begin
      state_q <= TS_IDLE;
      blk_q   <= 1'b0;
      unblk_q <= 1'b0;
    end else begin
      state_q <= state_d;
      blk_q   <= blk_d;
      unblk_q <= unblk_d;
    end
  end

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_q && unblk_q)); // R10

  AST_BLOCK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q |-> (state_q == TS_BLOCKED && $past(state_q) == TS_IDLE)); // R4

  AST_UNBLOCK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    unblk_q |-> (state_q == TS_IDLE)); // R6

  AST_SQUASH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (state_q == TS_IDLE && !blk_q)); // R9

endmodule

// File: rtl/dec_stall_ctl.sv
module dec_stall_ctl
  import dec_skid_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int STAGE_W     = 2,
  parameter int PC_W        = 32,
  parameter int SEQ_W       = 16,
  parameter int INST_BYTES  = 4,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   init,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [TID_W-1:0]       in_tid,
  input  logic [PC_W-1:0]        in_pc,
  input  logic [SEQ_W-1:0]       in_seq,
  input  logic [PC_W-1:0]        in_pred_npc,
  input  logic [PC_W-1:0]        in_real_npc,
  input  logic                   in_mispredict,
  input  logic [NUM_THREADS-1:0] ds_stall,
  output logic                   out_valid,
  output logic [TID_W-1:0]       out_tid,
  output logic [PC_W-1:0]        out_pc,
  output logic [SEQ_W-1:0]       out_seq,
  output logic [PC_W-1:0]        out_npc,
  output logic [NUM_THREADS-1:0] fe_block,
  output logic [NUM_THREADS-1:0] fe_unblock,
  output logic                   rd_valid,
  output logic                   rd_mispredict,
  output logic                   rd_pred_wrong,
  output logic [TID_W-1:0]       rd_tid,
  output logic [SEQ_W-1:0]       rd_seq,
  output logic [PC_W-1:0]        rd_npc,
  output logic                   rd_taken
);
  localparam int SKID_DEPTH = 2 * STAGE_W;
  localparam int CNT_W      = $clog2(SKID_DEPTH + 1);
  localparam int PKT_W      = 1 + SEQ_W + 3 * PC_W;

  logic [PKT_W-1:0]       in_pkt;
  logic [PKT_W-1:0]       head  [NUM_THREADS];
  logic [CNT_W-1:0]       cnt   [NUM_THREADS];
  tstate_e                st    [NUM_THREADS];
  logic [NUM_THREADS-1:0] full, in_hit, direct, want, grant, push, squash;

  logic [PKT_W-1:0]  emit_pkt;
  logic [TID_W-1:0]  emit_tid;
  logic              emit_v;
  logic              emit_mis;
  logic [SEQ_W-1:0]  emit_seq;
  logic [PC_W-1:0]   emit_pc, emit_pred, emit_real;

  assign in_pkt = {in_mispredict, in_seq, in_pc, in_pred_npc, in_real_npc};

  always_comb begin
    in_ready = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (in_tid == TID_W'(t)) in_ready = !full[t];
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign in_hit[t] = in_valid && in_ready && (in_tid == TID_W'(t));
    assign direct[t] = in_hit[t] && (st[t] == TS_IDLE) && !ds_stall[t];
    assign want[t]   = (st[t] == TS_UNBLOCKING) && !ds_stall[t] && (cnt[t] != '0);
    assign squash[t] = emit_v && emit_mis && (emit_tid == TID_W'(t));
    assign push[t]   = in_hit[t] && !direct[t] && !squash[t];

    dec_skid_fifo #(.DATA_W(PKT_W), .DEPTH(SKID_DEPTH)) u_skid (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (init || squash[t]),
      .push  (push[t]),
      .pop   (grant[t]),
      .wdata (in_pkt),
      .rdata (head[t]),
      .count (cnt[t]),
      .full  (full[t])
    );

    dec_thread_ctl #(.CNT_W(CNT_W)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .init    (init),
      .stall   (ds_stall[t]),
      .squash  (squash[t]),
      .push    (push[t]),
      .pop     (grant[t]),
      .count   (cnt[t]),
      .state_q (st[t]),
      .blk_q   (fe_block[t]),
      .unblk_q (fe_unblock[t])
    );
  end

  // Straight-through traffic owns the output; otherwise lowest replaying thread.
  always_comb begin
    logic found;
    grant = '0;
    found = |direct;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (!found && want[t]) begin
        grant[t] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    emit_pkt = in_pkt;
    emit_tid = in_tid;
    emit_v   = |direct;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (grant[t]) begin
        emit_pkt = head[t];
        emit_tid = TID_W'(t);
        emit_v   = 1'b1;
      end
    end
  end

  assign emit_mis  = emit_pkt[PKT_W-1];
  assign emit_seq  = emit_pkt[PKT_W-2 -: SEQ_W];
  assign emit_pc   = emit_pkt[3*PC_W-1 -: PC_W];
  assign emit_pred = emit_pkt[2*PC_W-1 -: PC_W];
  assign emit_real = emit_pkt[PC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_tid       <= '0;
      out_pc        <= '0;
      out_seq       <= '0;
      out_npc       <= '0;
      rd_valid      <= 1'b0;
      rd_mispredict <= 1'b0;
      rd_pred_wrong <= 1'b0;
      rd_tid        <= '0;
      rd_seq        <= '0;
      rd_npc        <= '0;
      rd_taken      <= 1'b0;
    end else if (init) begin
      out_valid     <= 1'b0;
      rd_valid      <= 1'b0;
      rd_mispredict <= 1'b0;
      rd_pred_wrong <= 1'b0;
    end else begin
      out_valid     <= emit_v;
      out_tid       <= emit_tid;
      out_pc        <= emit_pc;
      out_seq       <= emit_seq;
      out_npc       <= emit_mis ? emit_real : emit_pred;
      rd_valid      <= emit_v && emit_mis;
      rd_mispredict <= emit_v && emit_mis;
      rd_pred_wrong <= emit_v && emit_mis;
      rd_tid        <= emit_tid;
      rd_seq        <= emit_seq;
      rd_npc        <= emit_real;
      rd_taken      <= emit_real != (emit_pc + PC_W'(INST_BYTES));
    end
  end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|direct, grant})); // R12

  AST_REDIRECT_WITH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (out_valid && out_tid == rd_tid && out_seq == rd_seq)); // R7

  AST_NO_PUSH_AND_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|push, |direct})); // R3

endmodule

// File: tb/tb_dec_stall_ctl.sv
module tb_dec_stall_ctl;
  localparam int NT = 2;
  localparam int PW = 32;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [0:0] in_tid = '0;
  logic [PW-1:0] in_pc = '0, in_pred_npc = '0, in_real_npc = '0;
  logic [SW-1:0] in_seq = '0;
  logic in_mispredict = 1'b0;
  logic [NT-1:0] ds_stall = '0;
  logic out_valid;
  logic [0:0] out_tid;
  logic [PW-1:0] out_pc, out_npc;
  logic [SW-1:0] out_seq;
  logic [NT-1:0] fe_block, fe_unblock;
  logic rd_valid, rd_mispredict, rd_pred_wrong, rd_taken;
  logic [0:0] rd_tid;
  logic [SW-1:0] rd_seq;
  logic [PW-1:0] rd_npc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  dec_stall_ctl dut (
    .clk(clk), .rst_n(rst_n), .init(init),
    .in_valid(in_valid), .in_ready(in_ready), .in_tid(in_tid),
    .in_pc(in_pc), .in_seq(in_seq), .in_pred_npc(in_pred_npc),
    .in_real_npc(in_real_npc), .in_mispredict(in_mispredict),
    .ds_stall(ds_stall),
    .out_valid(out_valid), .out_tid(out_tid), .out_pc(out_pc),
    .out_seq(out_seq), .out_npc(out_npc),
    .fe_block(fe_block), .fe_unblock(fe_unblock),
    .rd_valid(rd_valid), .rd_mispredict(rd_mispredict),
    .rd_pred_wrong(rd_pred_wrong), .rd_tid(rd_tid), .rd_seq(rd_seq),
    .rd_npc(rd_npc), .rd_taken(rd_taken)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input int tid, input int pc, input int seq,
                     input int pred, input int real_npc, input bit mis);
    in_valid = 1'b1; in_tid = 1'(tid); in_pc = PW'(pc); in_seq = SW'(seq);
    in_pred_npc = PW'(pred); in_real_npc = PW'(real_npc); in_mispredict = mis;
  endtask

  task automatic none();
    in_valid = 1'b0; in_mispredict = 1'b0;
  endtask

  task automatic expect_out(input string req, input int tid, input int seq);
    chk(req, "out_valid", 64'(out_valid), 64'd1);
    chk(req, "out_tid", 64'(out_tid), 64'(tid));
    chk(req, "out_seq", 64'(out_seq), 64'(seq));
  endtask

  task automatic t_reset();
    chk("R1", "out_valid", 64'(out_valid), 0);
    chk("R1", "fe_block", 64'(fe_block), 0);
    chk("R1", "fe_unblock", 64'(fe_unblock), 0);
    chk("R1", "rd_valid", 64'(rd_valid), 0);
    chk("R1", "in_ready", 64'(in_ready), 1);
  endtask

  task automatic t_pass();
    put(0, 'h1000, 1, 'h1004, 'h1004, 0);
    tick();
    expect_out("R2", 0, 1);
    chk("R2", "out_pc", 64'(out_pc), 64'h1000);
    chk("R2", "out_npc", 64'(out_npc), 64'h1004);
    chk("R2", "rd_valid", 64'(rd_valid), 0);
    none(); tick();
    chk("R2", "out_valid idle", 64'(out_valid), 0);
  endtask

  task automatic t_order();
    ds_stall[0] = 1'b1; put(0, 'h2000, 10, 'h2004, 'h2004, 0); tick();
    chk("R4", "block pulse", 64'(fe_block[0]), 1);
    chk("R3", "held out", 64'(out_valid), 0);
    put(0, 'h2004, 11, 'h2008, 'h2008, 0); tick();
    chk("R4", "no repeat block", 64'(fe_block[0]), 0);
    chk("R3", "held out 2", 64'(out_valid), 0);
    ds_stall[0] = 1'b0; put(0, 'h2008, 12, 'h200c, 'h200c, 0); tick();
    chk("R5", "no output while leaving blocked", 64'(out_valid), 0);
    put(0, 'h200c, 13, 'h2010, 'h2010, 0); tick();
    expect_out("R5", 0, 10);
    none(); tick(); expect_out("R5", 0, 11);
    tick(); expect_out("R5", 0, 12);
    chk("R6", "no early unblock", 64'(fe_unblock[0]), 0);
    tick(); expect_out("R5", 0, 13);
    chk("R6", "unblock pulse", 64'(fe_unblock[0]), 1);
    chk("R10", "block with unblock", 64'(fe_block[0]), 0);
    tick();
    chk("R6", "single unblock", 64'(fe_unblock[0]), 0);
    chk("R6", "drained", 64'(out_valid), 0);
  endtask

  task automatic t_reblock();
    ds_stall[0] = 1'b1; put(0, 'h2100, 20, 'h2104, 'h2104, 0); tick();
    chk("R4", "block pulse", 64'(fe_block[0]), 1);
    put(0, 'h2104, 21, 'h2108, 'h2108, 0); tick();
    ds_stall[0] = 1'b0; none(); tick();
    tick(); expect_out("R5", 0, 20);
    ds_stall[0] = 1'b1; tick();
    chk("R4", "no block on reblock", 64'(fe_block[0]), 0);
    chk("R3", "held on reblock", 64'(out_valid), 0);
    ds_stall[0] = 1'b0; tick();
    chk("R5", "none while leaving blocked", 64'(out_valid), 0);
    tick(); expect_out("R5", 0, 21);
    chk("R6", "unblock after reblock", 64'(fe_unblock[0]), 1);
    tick();
    chk("R6", "unblock once", 64'(fe_unblock[0]), 0);
  endtask

  task automatic t_mispredict();
    put(1, 'h3000, 30, 'h3004, 'h3800, 1); tick();
    expect_out("R7", 1, 30);
    chk("R7", "out_npc corrected", 64'(out_npc), 64'h3800);
    chk("R7", "rd_valid", 64'(rd_valid), 1);
    chk("R7", "rd_mispredict", 64'(rd_mispredict), 1);
    chk("R7", "rd_pred_wrong", 64'(rd_pred_wrong), 1);
    chk("R7", "rd_tid", 64'(rd_tid), 1);
    chk("R7", "rd_seq", 64'(rd_seq), 30);
    chk("R7", "rd_npc", 64'(rd_npc), 64'h3800);
    chk("R8", "taken", 64'(rd_taken), 1);
    chk("R9", "idle squash no unblock", 64'(fe_unblock[1]), 0);
    put(1, 'h3100, 31, 'h3400, 'h3104, 1); tick();
    chk("R8", "not taken", 64'(rd_taken), 0);
    chk("R7", "out_npc fallthrough", 64'(out_npc), 64'h3104);
    none(); tick();
    chk("R7", "rd_valid clears", 64'(rd_valid), 0);
  endtask

  task automatic t_squash_skid();
    ds_stall[0] = 1'b1; put(0, 'h4000, 40, 'h4004, 'h4040, 1); tick();
    put(0, 'h4040, 41, 'h4044, 'h4044, 0); tick();
    ds_stall[0] = 1'b0; none(); tick();
    put(0, 'h4044, 42, 'h4048, 'h4048, 0); tick();
    expect_out("R9", 0, 40);
    chk("R9", "squash redirect", 64'(rd_valid), 1);
    chk("R9", "unblock on squash", 64'(fe_unblock[0]), 1);
    chk("R9", "no block on squash", 64'(fe_block[0]), 0);
    none(); tick();
    chk("R9", "flushed", 64'(out_valid), 0);
    chk("R9", "single unblock", 64'(fe_unblock[0]), 0);
    put(0, 'h5000, 43, 'h5004, 'h5004, 0); tick();
    expect_out("R9", 0, 43);
    none(); tick();
  endtask

  task automatic t_full();
    ds_stall[1] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      put(1, 'h6000 + 4 * i, 50 + i, 'h6004 + 4 * i, 'h6004 + 4 * i, 0);
      #1 chk("R11", "ready with space", 64'(in_ready), 1);
      tick();
    end
    put(1, 'h6010, 54, 'h6014, 'h6014, 0);
    #1 chk("R11", "ready low when full", 64'(in_ready), 0);
    in_tid = 1'b0;
    #1 chk("R11", "other thread ready", 64'(in_ready), 1);
    in_tid = 1'b1;
    tick();
    none(); ds_stall[1] = 1'b0; tick();
    for (int i = 0; i < 4; i++) begin
      tick(); expect_out("R11", 1, 50 + i);
    end
    chk("R6", "unblock after full drain", 64'(fe_unblock[1]), 1);
    tick();
    chk("R11", "rejected lost", 64'(out_valid), 0);
  endtask

  task automatic t_arb();
    ds_stall[0] = 1'b1; put(0, 'h7000, 60, 'h7004, 'h7004, 0); tick();
    ds_stall[0] = 1'b0; none(); tick();
    put(1, 'h7100, 61, 'h7104, 'h7104, 0); tick();
    expect_out("R12", 1, 61);
    none(); tick();
    expect_out("R12", 0, 60);
    chk("R6", "unblock after arb", 64'(fe_unblock[0]), 1);
    ds_stall[0] = 1'b1; put(1, 'h7200, 62, 'h7204, 'h7204, 0); tick();
    expect_out("R13", 1, 62);
    chk("R13", "t0 blocks", 64'(fe_block[0]), 1);
    chk("R13", "t1 unaffected", 64'(fe_block[1]), 0);
    ds_stall[0] = 1'b0; none(); tick();
    chk("R6", "empty release unblock", 64'(fe_unblock[0]), 1);
    chk("R6", "empty release no out", 64'(out_valid), 0);
  endtask

  task automatic t_takeover();
    ds_stall[0] = 1'b1; put(0, 'h8000, 70, 'h8004, 'h8004, 0); tick();
    none(); init = 1'b1; tick();
    init = 1'b0;
    chk("R1", "init block cleared", 64'(fe_block), 0);
    chk("R1", "init out", 64'(out_valid), 0);
    ds_stall[0] = 1'b0; tick();
    chk("R1", "no stale replay", 64'(out_valid), 0);
    chk("R1", "no unblock after init", 64'(fe_unblock), 0);
    put(0, 'h8100, 71, 'h8104, 'h8104, 0); tick();
    expect_out("R1", 0, 71);
    none(); tick();
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_order();
    t_reblock();
    t_mispredict();
    t_squash_skid();
    t_full();
    t_arb();
    t_takeover();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule